// File: doc/BRIEF.md
# Byte-Wide SPI Master with Register Bus

This block is an SPI master with a single chip-select line, attached to a simple 32-bit register bus. Software picks the clock mode and rate in a control register, drives the chip-select level itself through a system register, and then writes one byte to the transmit register. The block shifts that byte out most-significant bit first while it shifts a byte in from the slave. When the eight bits are exchanged, the received byte sits in the receive register and a receive-full flag is raised.

The serial clock is derived from the system clock in two stages. A fixed prescaler divides by a low or a high ratio (16 or 128 by default). A second stage divides by 2×(N+1), with N a 5-bit field. All four combinations of clock polarity and phase are supported. Mode and rate are captured when a frame starts, so software may rewrite the control register while a byte is in flight.

Top module: `spi_host`

## Requirements
- R1: After reset every register reads 0, cs_no is 1, sclk_o is 0 and the busy flag (status bit 0) is 0.
- R2: Word offsets 0x00 (control, bits 7:0), 0x08 (system, bits 7:0) and 0x14 (second control, bits 31:0) read back what was written. Status is at 0x04, transmit at 0x0C and receive at 0x10. Other addresses read 0.
- R3: With control bit 5 = 0 the prescale P is PRE_LO, and with bit 5 = 1 it is PRE_HI. Control bits 4:0 hold N. Each sclk half period lasts P×(N+1) clocks, and busy stays high for exactly 16×P×(N+1) clocks, counted from the clock edge that accepts the transmit write.
- R4: sclk_o rests at CPOL (control bit 6) while idle. It makes exactly 16 transitions per frame and ends the frame back at CPOL.
- R5: mosi_o carries the transmit byte MSB first. With CPHA (control bit 7) = 0, each bit is valid before its leading clock edge and the slave samples it on that edge. With CPHA = 1, a bit changes on each leading edge and the slave samples it on the trailing edge.
- R6: The block samples miso_i on the same edges as the slave, MSB first. The receive register (0x10, bits 7:0) holds the byte received in the last frame.
- R7: Status bit 2 (receive full) rises on the edge that ends a frame. Reading the receive register clears it.
- R8: Writing the status register with bit 2 = 0 clears receive full. A status write never changes busy.
- R9: cs_no is 0 only when system bit 0 (enable) = 1, bit 5 (software select) = 1 and bit 6 (level) = 0. Writing 0x21 therefore asserts chip select, and setting bit 6 releases it.
- R10: A transmit write is ignored while busy or while system bit 0 = 0. The frame in flight is not restarted or altered, and no frame starts.
- R11: Control writes during a frame take effect only at the next frame. The running frame keeps its duration and its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | AW | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of the read strobe |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 1 | Chip select, active low |

## Verification
The bench builds the block with PRE_LO = 2 and PRE_HI = 4 instead of 16 and 128. The longest frame then takes 2048 clocks, so the full range of N can be swept in one mode, and both prescale settings at N = 0 and N = 31 can be run in all four clock modes. A behavioural slave follows sclk_o, captures mosi_o and returns its own byte. Exchanged data, the frame length in clocks and the number of sclk transitions are all compared against values the bench computes from P, N, CPOL and CPHA.

// File: rtl/spi_host_pkg.sv
`timescale 1ns/1ps
package spi_host_pkg;
  localparam int unsigned AW = 5;

  localparam logic [AW-1:0] OFS_CTRL  = 5'h00;
  localparam logic [AW-1:0] OFS_STAT  = 5'h04;
  localparam logic [AW-1:0] OFS_SYS   = 5'h08;
  localparam logic [AW-1:0] OFS_TX    = 5'h0C;
  localparam logic [AW-1:0] OFS_RX    = 5'h10;
  localparam logic [AW-1:0] OFS_CTRL2 = 5'h14;

  localparam int unsigned STAT_BUSY = 0;
  localparam int unsigned STAT_RXF  = 2;
  localparam int unsigned SYS_EN    = 0;
  localparam int unsigned SYS_SWCS  = 5;
  localparam int unsigned SYS_LVL   = 6;

  localparam int unsigned N_W = 5;

  typedef struct packed {
    logic           cpha;
    logic           cpol;
    logic           pre_hi;
    logic [N_W-1:0] n;
  } ctrl_t;
endpackage

// File: rtl/spi_host_div.sv
`timescale 1ns/1ps
module spi_host_div #(
  parameter int unsigned PRE_LO = 16,
  parameter int unsigned PRE_HI = 128,
  parameter int unsigned N_W    = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           run_i,
  input  logic           pre_hi_i,
  input  logic [N_W-1:0] n_i,
  output logic           half_tick_o
);
  localparam int unsigned PC_W = (PRE_HI > 2) ? $clog2(PRE_HI) : 1;
  localparam logic [PC_W-1:0] LIM_LO = PC_W'(PRE_LO - 1);
  localparam logic [PC_W-1:0] LIM_HI = PC_W'(PRE_HI - 1);

  logic [PC_W-1:0] pre_cnt;
  logic [N_W-1:0]  div_cnt, lat_n;
  logic            lat_hi;
  logic            pre_wrap, div_wrap;

  assign pre_wrap    = pre_cnt == (lat_hi ? LIM_HI : LIM_LO);
  assign div_wrap    = div_cnt == lat_n;
  assign half_tick_o = run_i && pre_wrap && div_wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_cnt <= '0;
      div_cnt <= '0;
      lat_n   <= '0;
      lat_hi  <= 1'b0;
    end else if (load_i) begin
      // rate captured at frame start
      pre_cnt <= '0;
      div_cnt <= '0;
      lat_n   <= n_i;
      lat_hi  <= pre_hi_i;
    end else if (run_i) begin
      pre_cnt <= pre_wrap ? '0 : pre_cnt + 1'b1;
      if (pre_wrap) div_cnt <= div_wrap ? '0 : div_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_host_shift.sv
`timescale 1ns/1ps
module spi_host_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] tx_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              half_tick_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic [DATA_W-1:0] rx_o
);
  localparam int unsigned EDGES = 2 * DATA_W;
  localparam int unsigned EW    = $clog2(EDGES);
  localparam logic [EW-1:0] LAST = EW'(EDGES - 1);

  logic [DATA_W-1:0] tx_sh, rx_sh, rx_nxt, rx_q;
  logic [EW-1:0]     edge_cnt;
  logic              busy_q, sclk_q, pha_q;
  logic              lead, smp, shf, last;

  assign lead   = !edge_cnt[0];
  assign last   = edge_cnt == LAST;
  assign smp    = pha_q ? !lead : lead;
  assign shf    = pha_q ? (lead && edge_cnt != '0) : !lead;
  assign rx_nxt = smp ? {rx_sh[DATA_W-2:0], miso_i} : rx_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      sclk_q   <= 1'b0;
      pha_q    <= 1'b0;
      edge_cnt <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      rx_q     <= '0;
    end else if (start_i) begin
      busy_q   <= 1'b1;
      sclk_q   <= cpol_i;
      pha_q    <= cpha_i;
      edge_cnt <= '0;
      tx_sh    <= tx_i;
    end else if (busy_q && half_tick_i) begin
      sclk_q   <= ~sclk_q;
      edge_cnt <= edge_cnt + 1'b1;
      rx_sh    <= rx_nxt;
      if (shf) tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
      if (last) begin
        busy_q <= 1'b0;
        rx_q   <= rx_nxt;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && half_tick_i && last;
  assign sclk_o = busy_q ? sclk_q : cpol_i;
  assign mosi_o = tx_sh[DATA_W-1];
  assign rx_o   = rx_q;
endmodule

// File: rtl/spi_host.sv
`timescale 1ns/1ps
module spi_host
  import spi_host_pkg::*;
#(
  parameter int unsigned PRE_LO = 16,
  parameter int unsigned PRE_HI = 128,
  parameter int unsigned DATA_W = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_req_i,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [31:0]   bus_wdata_i,
  output logic [31:0]   bus_rdata_o,
  output logic          sclk_o,
  output logic          mosi_o,
  input  logic          miso_i,
  output logic          cs_no
);
  ctrl_t             ctrl_q;
  logic [7:0]        sys_q;
  logic [31:0]       ctrl2_q;
  logic              rxf_q;
  logic              wr, rd, tx_go, stat_clr, rx_rd;
  logic              busy, done, half_tick, idle_pol;
  logic [DATA_W-1:0] rx_data;

  assign wr       = bus_req_i && bus_we_i;
  assign rd       = bus_req_i && !bus_we_i;
  assign tx_go    = wr && bus_addr_i == OFS_TX && !busy && sys_q[SYS_EN];
  assign stat_clr = wr && bus_addr_i == OFS_STAT && !bus_wdata_i[STAT_RXF];
  assign rx_rd    = rd && bus_addr_i == OFS_RX;
  assign idle_pol = ctrl_q.cpol;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      sys_q   <= '0;
      ctrl2_q <= '0;
      rxf_q   <= 1'b0;
    end else begin
      if (wr && bus_addr_i == OFS_CTRL)  ctrl_q  <= ctrl_t'(bus_wdata_i[7:0]);
      if (wr && bus_addr_i == OFS_SYS)   sys_q   <= bus_wdata_i[7:0];
      if (wr && bus_addr_i == OFS_CTRL2) ctrl2_q <= bus_wdata_i;
      // a finishing frame wins over any clear in the same cycle
      if (done)                      rxf_q <= 1'b1;
      else if (stat_clr || rx_rd)    rxf_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (rd) begin
      case (bus_addr_i)
        OFS_CTRL:  bus_rdata_o[7:0] = ctrl_q;
        OFS_STAT: begin
          bus_rdata_o[STAT_BUSY] = busy;
          bus_rdata_o[STAT_RXF]  = rxf_q;
        end
        OFS_SYS:   bus_rdata_o[7:0] = sys_q;
        OFS_RX:    bus_rdata_o[DATA_W-1:0] = rx_data;
        OFS_CTRL2: bus_rdata_o = ctrl2_q;
        default:   bus_rdata_o = '0;
      endcase
    end
  end

  assign cs_no = !(sys_q[SYS_EN] && sys_q[SYS_SWCS] && !sys_q[SYS_LVL]);

  spi_host_div #(
    .PRE_LO (PRE_LO),
    .PRE_HI (PRE_HI),
    .N_W    (N_W)
  ) u_div (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (tx_go),
    .run_i       (busy),
    .pre_hi_i    (ctrl_q.pre_hi),
    .n_i         (ctrl_q.n),
    .half_tick_o (half_tick)
  );

  spi_host_shift #(
    .DATA_W (DATA_W)
  ) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (tx_go),
    .tx_i        (bus_wdata_i[DATA_W-1:0]),
    .cpol_i      (ctrl_q.cpol),
    .cpha_i      (ctrl_q.cpha),
    .half_tick_i (half_tick),
    .miso_i      (miso_i),
    .busy_o      (busy),
    .done_o      (done),
    .sclk_o      (sclk_o),
    .mosi_o      (mosi_o),
    .rx_o        (rx_data)
  );
endmodule

// File: rtl/spi_host_chk.sv
`timescale 1ns/1ps
module spi_host_chk #(
  parameter int unsigned MAX_CYC = 65536
) (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_i,
  input logic rxf_i,
  input logic tick_i,
  input logic sclk_i,
  input logic cpol_i,
  input logic stat_clr_i
);
  int unsigned busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      busy_cnt <= 0;
    else if (!busy_i) busy_cnt <= 0;
    else              busy_cnt <= busy_cnt + 1;
  end

  a_r7_rxf_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> rxf_i);

  a_r3_sclk_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> ((sclk_i != $past(sclk_i)) == $past(tick_i)));

  a_r3_frame_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> busy_cnt < MAX_CYC);

  a_r8_status_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_clr_i && !busy_i) |=> !rxf_i);

  a_r4_idle_sclk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !$past(busy_i) && $stable(cpol_i)) |-> $stable(sclk_i));
endmodule

bind spi_host spi_host_chk #(
  .MAX_CYC (2 * DATA_W * PRE_HI * 32)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_i     (busy),
  .rxf_i      (rxf_q),
  .tick_i     (half_tick),
  .sclk_i     (sclk_o),
  .cpol_i     (idle_pol),
  .stat_clr_i (stat_clr)
);

// File: tb/sim_spi_host.sv
`timescale 1ns/1ps
module sim_spi_host;
  localparam int unsigned PLO = 2;
  localparam int unsigned PHI = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sclk, mosi, cs_n;
  logic        miso;

  int unsigned cyc = 0;
  int          n_chk = 0, n_fail = 0;
  bit          done_flag = 0;

  // slave model state
  bit          s_act = 0;
  bit          s_pol = 0, s_pha = 0;
  logic [7:0]  s_byte = '0, s_cap = '0;
  int          s_k = 0, s_bit = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign miso = s_byte[3'(7 - (s_bit > 7 ? 7 : s_bit))];

  spi_host #(.PRE_LO(PLO), .PRE_HI(PHI), .DATA_W(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .cs_no(cs_n));

  always @(sclk) begin
    if (s_act) begin
      bit lead;
      lead = (sclk != s_pol);
      if (s_pha ? !lead : lead) s_cap = {s_cap[6:0], mosi};
      if (s_pha ? (lead && s_k > 0) : !lead) s_bit = s_bit + 1;
      s_k = s_k + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1; we = 0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    req = 0;
  endtask

  task automatic wait_idle();
    req = 1; we = 0; addr = 5'h04;
    #1;
    while (rdata[0]) begin
      @(negedge clk);
      #1;
    end
    req = 0;
  endtask

  task automatic arm_slave(input logic [7:0] sb, input bit pol, input bit pha);
    s_byte = sb; s_pol = pol; s_pha = pha;
    s_k = 0; s_bit = 0; s_cap = '0; s_act = 1;
  endtask

  // full frame with all per-frame checks
  task automatic frame(input bit pol, input bit pha, input bit hi, input int n,
                       input logic [7:0] tx, input logic [7:0] sb);
    logic [31:0] d;
    int unsigned t0, dur, exp_dur;
    bus_wr(5'h00, {24'd0, pha, pol, hi, 5'(n)});
    arm_slave(sb, pol, pha);
    bus_wr(5'h0C, {24'd0, tx});
    t0 = cyc;
    wait_idle();
    dur = cyc - t0;
    exp_dur = 16 * (hi ? PHI : PLO) * (n + 1);
    s_act = 0;
    check(dur == exp_dur, "R3 frame length", dur, exp_dur);
    check(s_k == 16, "R4 sclk transitions", s_k, 16);
    check(sclk == pol, "R4 sclk rest level", sclk, pol);
    check(s_cap == tx, "R5 mosi byte", s_cap, tx);
    bus_rd(5'h04, d);
    check(d[2] == 1'b1, "R7 rx full set", d[2], 1);
    bus_rd(5'h10, d);
    check(d[7:0] == sb, "R6 rx byte", d[7:0], sb);
    bus_rd(5'h04, d);
    check(d[2] == 1'b0, "R7 rx full cleared by read", d[2], 0);
  endtask

  initial begin
    logic [31:0] d;
    logic [7:0]  tx, sb;
    int unsigned t0, dur;
    #20 rst_n = 1;

    // R1 reset state
    foreach (d[i]) ;
    for (int a = 0; a < 6; a++) begin
      bus_rd(5'(a * 4), d);
      check(d == 0, "R1 register reset", d, 0);
    end
    check(cs_n == 1'b1, "R1 cs high", cs_n, 1);
    check(sclk == 1'b0, "R1 sclk low", sclk, 0);

    // R2 readback and unmapped address
    bus_wr(5'h14, 32'hDEAD_BEEF);
    bus_rd(5'h14, d);
    check(d == 32'hDEAD_BEEF, "R2 ctrl2 readback", d, 32'hDEAD_BEEF);
    bus_wr(5'h00, 32'hFFFF_FFB7);
    bus_rd(5'h00, d);
    check(d == 32'hB7, "R2 ctrl readback", d, 32'hB7);
    check(sclk == 1'b0, "R4 idle sclk follows cpol=0", sclk, 0);
    bus_wr(5'h00, 32'h40);
    check(sclk == 1'b1, "R4 idle sclk follows cpol=1", sclk, 1);
    bus_rd(5'h18, d);
    check(d == 0, "R2 unmapped reads zero", d, 0);

    // R10 transmit ignored while disabled
    arm_slave(8'h00, 1'b1, 1'b0);
    bus_wr(5'h0C, 32'h5A);
    bus_rd(5'h04, d);
    check(d[0] == 1'b0, "R10 no frame when disabled", d[0], 0);
    s_act = 0;
    check(s_k == 0, "R10 no sclk when disabled", s_k, 0);

    // R9 chip select decode
    bus_wr(5'h08, 32'h21);
    check(cs_n == 1'b0, "R9 0x21 asserts cs", cs_n, 0);
    bus_rd(5'h08, d);
    check(d == 32'h21, "R2 system readback", d, 32'h21);
    bus_wr(5'h08, 32'h61);
    check(cs_n == 1'b1, "R9 level bit releases cs", cs_n, 1);
    bus_wr(5'h08, 32'h01);
    check(cs_n == 1'b1, "R9 software select off", cs_n, 1);
    bus_wr(5'h08, 32'h20);
    check(cs_n == 1'b1, "R9 enable off", cs_n, 1);
    bus_wr(5'h08, 32'h21);

    // sweep N fully in mode 0, low prescale
    for (int n = 0; n < 32; n++) begin
      tx = 8'hA5 ^ 8'(n * 37);
      sb = {tx[3:0], tx[7:4]} ^ 8'h3C;
      frame(1'b0, 1'b0, 1'b0, n, tx, sb);
    end
    // all modes, both prescales, N extremes
    for (int m = 0; m < 4; m++)
      for (int h = 0; h < 2; h++)
        for (int k = 0; k < 2; k++) begin
          int n;
          n  = k ? 31 : 0;
          tx = 8'h81 ^ 8'(m * 29 + h * 101 + n);
          sb = ~tx ^ 8'(m * 17);
          frame(m[1], m[0], h[0], n, tx, sb);
        end

    // R8 status write clears rx full, busy unaffected
    frame(1'b1, 1'b1, 1'b0, 0, 8'h3C, 8'hC3);
    bus_wr(5'h00, 32'h00);
    arm_slave(8'h96, 1'b0, 1'b0);
    bus_wr(5'h0C, 32'h69);
    wait_idle();
    s_act = 0;
    bus_wr(5'h04, 32'h0);
    bus_rd(5'h04, d);
    check(d[2] == 1'b0, "R8 status write clears rx full", d[2], 0);
    bus_rd(5'h10, d);
    check(d[7:0] == 8'h96, "R8 rx data kept after clear", d[7:0], 8'h96);
    arm_slave(8'h11, 1'b0, 1'b0);
    bus_wr(5'h0C, 32'h22);
    bus_wr(5'h04, 32'h0);
    bus_rd(5'h04, d);
    check(d[0] == 1'b1, "R8 status write keeps busy", d[0], 1);
    wait_idle();
    s_act = 0;
    bus_rd(5'h10, d);

    // R10 transmit write while busy ignored; R11 ctrl write mid-frame deferred
    bus_wr(5'h00, 32'h01);
    arm_slave(8'hE7, 1'b0, 1'b0);
    bus_wr(5'h0C, 32'hC6);
    t0 = cyc;
    bus_wr(5'h0C, 32'h39);
    bus_wr(5'h00, 32'h25);
    wait_idle();
    dur = cyc - t0;
    s_act = 0;
    check(dur == 16 * PLO * 2, "R11 frame length kept", dur, 16 * PLO * 2);
    check(s_k == 16, "R10 frame not restarted", s_k, 16);
    check(s_cap == 8'hC6, "R10 first byte sent", s_cap, 8'hC6);
    bus_rd(5'h10, d);
    check(d[7:0] == 8'hE7, "R11 rx byte intact", d[7:0], 8'hE7);
    // next frame uses the new setting: P=PHI, N=5
    frame(1'b0, 1'b0, 1'b1, 5, 8'h5E, 8'hA1);

    done_flag = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    if (!done_flag && cyc > 190000) begin
      done_flag = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule